// File: doc/BRIEF.md
# Dual-Path Operand Collector with Split-Lane Execution

This block sits between two independent warp issue paths and a register file that offers each path a single read port. For every instruction accepted on a path, it fetches the two source registers one after the other through that path's port, holds each returned 32-thread register in a per-path staging entry, and dispatches to a 16-lane adder/subtractor only once both staging slots are marked valid. The 32 threads are computed as two passes of 16 lanes on consecutive cycles: threads 0 to 15 first, then threads 16 to 31. The combined result is then presented on the path's write-back port together with the warp number and destination register.

The two paths share nothing. Each has its own collector entry, read port, adder and write-back port, so instructions from both issue paths move through reading, staging, execution and write-back side by side. A path holds only one instruction at a time and drops its ready flag while that instruction is in flight.

Top module: `opc_pair`

## Requirements
- R1: After reset, every path shows in_ready high, rf_rd_en low and wb_valid low.
- R2: A path accepts an instruction on a clock edge where in_valid and in_ready are both high; in_ready is low from the next cycle until its write-back cycle has ended, and an in_valid presented while in_ready is low has no effect on what that path reads or writes back.
- R3: In the first cycle after acceptance the path asserts rf_rd_en with the accepted warp and the first source register number, and in the second cycle with the same warp and the second source register number; the register file returns the 32-lane word one cycle after each read request.
- R4: wb_valid is high for exactly one cycle, the sixth cycle after the accepting edge.
- R5: With op code 0 each of the 32 thread results equals first source plus second source modulo 2^32, the lanes being computed as a lower 16-lane pass followed by an upper 16-lane pass.
- R6: With op code 1 each thread result equals first source minus second source modulo 2^32; naming the same register as both sources yields zero in every lane.
- R7: During write-back, wb_warp and wb_reg equal the warp and destination register of the accepted instruction.
- R8: The two paths operate independently and can accept, read, execute and write back in the same cycles, each through its own read port.
- R9: Execution starts only after both source registers have been captured; no read request and no write-back occurs in the three cycles between the second read and write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NPATH | Instruction offered, one bit per path |
| in_ready | output | NPATH | Path can take an instruction |
| in_warp | input | NPATH*WARP_W | Warp number per path |
| in_op | input | NPATH | Operation per path: 0 add, 1 subtract |
| in_src_a | input | NPATH*REG_W | First source register per path |
| in_src_b | input | NPATH*REG_W | Second source register per path |
| in_dst | input | NPATH*REG_W | Destination register per path |
| rf_rd_en | output | NPATH | Register read request per path |
| rf_rd_warp | output | NPATH*WARP_W | Warp half of the read index |
| rf_rd_reg | output | NPATH*REG_W | Register half of the read index |
| rf_rd_data | input | NPATH*THREADS*DW | Read data, one cycle after the request |
| wb_valid | output | NPATH | Write-back strobe per path |
| wb_warp | output | NPATH*WARP_W | Warp being written |
| wb_reg | output | NPATH*REG_W | Register being written |
| wb_data | output | NPATH*THREADS*DW | 32-lane result per path |

## Verification
The properties assume that the register file answers each read request with data on the following cycle and that the issue side samples in_ready before relying on acceptance; fields presented with in_valid are arbitrary. The bench models the register file as a registered lookup whose per-lane contents are a fixed hash of path, warp, register and lane, so every returned word is known without storing a memory. Random stimulus keeps in_valid toggling whether or not a path is busy, which exercises the ignored-while-busy case, and directed instructions start both paths on the same edge with a repeated source register and with the extreme warp and register numbers.

// File: rtl/opc_pkg.sv
package opc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RDA,
      ST_RDB,
      ST_CAPB,
      ST_EXEC,
      ST_WB
   } coll_st_e;

   localparam logic OP_ADD = 1'b0;
   localparam logic OP_SUB = 1'b1;

endpackage

// File: rtl/opc_lane_alu.sv
module opc_lane_alu #(
   parameter int LANES       = 16,
   parameter int DW          = 32,
   parameter int ADDER_STYLE = 0
) (
   input  logic [LANES*DW-1:0] a,
   input  logic [LANES*DW-1:0] b,
   input  logic                op,
   output logic [LANES*DW-1:0] y
);

   if (LANES < 1) begin : g_bad_lanes
      $error("opc_lane_alu: LANES must be at least 1");
   end
   if (DW < 1) begin : g_bad_dw
      $error("opc_lane_alu: DW must be at least 1");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [DW-1:0] la, lb;
      assign la = a[l*DW +: DW];
      assign lb = b[l*DW +: DW];
      if (ADDER_STYLE == 0) begin : g_mux
         assign y[l*DW +: DW] = (op == opc_pkg::OP_SUB) ? (la - lb) : (la + lb);
      end else begin : g_shared
         assign y[l*DW +: DW] = la + (lb ^ {DW{op}}) + DW'(op);
      end
   end

endmodule

// File: rtl/opc_collector.sv
module opc_collector #(
   parameter int DW          = 32,
   parameter int THREADS     = 32,
   parameter int LANES       = 16,
   parameter int WARP_W      = 3,
   parameter int REG_W       = 5,
   parameter int ADDER_STYLE = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [WARP_W-1:0]       in_warp,
   input  logic                    in_op,
   input  logic [REG_W-1:0]        in_src_a,
   input  logic [REG_W-1:0]        in_src_b,
   input  logic [REG_W-1:0]        in_dst,
   output logic                    rf_rd_en,
   output logic [WARP_W-1:0]       rf_rd_warp,
   output logic [REG_W-1:0]        rf_rd_reg,
   input  logic [THREADS*DW-1:0]   rf_rd_data,
   output logic                    wb_valid,
   output logic [WARP_W-1:0]       wb_warp,
   output logic [REG_W-1:0]        wb_reg,
   output logic [THREADS*DW-1:0]   wb_data
);
   import opc_pkg::*;

   localparam int NPASS  = THREADS / LANES;
   localparam int SLICE  = LANES * DW;
   localparam int FULL   = THREADS * DW;
   localparam int PASS_W = (NPASS > 1) ? $clog2(NPASS) : 1;

   if (THREADS % LANES != 0) begin : g_bad_split
      $error("opc_collector: THREADS must be a multiple of LANES");
   end

   coll_st_e          state_q;
   logic [WARP_W-1:0] warp_q;
   logic              op_q;
   logic [REG_W-1:0]  sa_q, sb_q, dst_q;
   logic [FULL-1:0]   opa_q, opb_q, res_q;
   logic              va_q, vb_q;
   logic [PASS_W-1:0] pass_q;
   logic              last_pass;
   logic [SLICE-1:0]  alu_a, alu_b, alu_y;

   assign last_pass = (pass_q == PASS_W'(NPASS - 1));
   assign alu_a     = opa_q[pass_q*SLICE +: SLICE];
   assign alu_b     = opb_q[pass_q*SLICE +: SLICE];

   opc_lane_alu #(
      .LANES      (LANES),
      .DW         (DW),
      .ADDER_STYLE(ADDER_STYLE)
   ) u_alu (
      .a (alu_a),
      .b (alu_b),
      .op(op_q),
      .y (alu_y)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         va_q    <= 1'b0;
         vb_q    <= 1'b0;
         pass_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (in_valid) state_q <= ST_RDA;
            ST_RDA:  state_q <= ST_RDB;
            ST_RDB: begin
               va_q    <= 1'b1;
               state_q <= ST_CAPB;
            end
            ST_CAPB: begin
               vb_q    <= 1'b1;
               pass_q  <= '0;
               state_q <= ST_EXEC;
            end
            ST_EXEC: begin
               if (last_pass) state_q <= ST_WB;
               else           pass_q  <= pass_q + 1'b1;
            end
            ST_WB: begin
               va_q    <= 1'b0;
               vb_q    <= 1'b0;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (state_q == ST_IDLE && in_valid) begin
         warp_q <= in_warp;
         op_q   <= in_op;
         sa_q   <= in_src_a;
         sb_q   <= in_src_b;
         dst_q  <= in_dst;
      end
      if (state_q == ST_RDB)  opa_q <= rf_rd_data;
      if (state_q == ST_CAPB) opb_q <= rf_rd_data;
      if (state_q == ST_EXEC) res_q[pass_q*SLICE +: SLICE] <= alu_y;
   end

   assign in_ready   = (state_q == ST_IDLE);
   assign rf_rd_en   = (state_q == ST_RDA) || (state_q == ST_RDB);
   assign rf_rd_warp = warp_q;
   assign rf_rd_reg  = (state_q == ST_RDA) ? sa_q : sb_q;
   assign wb_valid   = (state_q == ST_WB);
   assign wb_warp    = warp_q;
   assign wb_reg     = dst_q;
   assign wb_data    = res_q;

   p_accept_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   p_first_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=>
         (rf_rd_en && rf_rd_reg == $past(in_src_a) && rf_rd_warp == $past(in_warp)));

   p_second_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rf_rd_en) |=> (rf_rd_en && $stable(rf_rd_warp)));

   p_exec_ops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EXEC) |-> (va_q && vb_q));

   p_wb_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |=> !wb_valid);

   p_wb_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (!rf_rd_en && !$past(rf_rd_en)));

endmodule

// File: rtl/opc_pair.sv
module opc_pair #(
   parameter int NPATH       = 2,
   parameter int DW          = 32,
   parameter int THREADS     = 32,
   parameter int LANES       = 16,
   parameter int WARP_W      = 3,
   parameter int REG_W       = 5,
   parameter int ADDER_STYLE = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NPATH-1:0]              in_valid,
   output logic [NPATH-1:0]              in_ready,
   input  logic [NPATH*WARP_W-1:0]       in_warp,
   input  logic [NPATH-1:0]              in_op,
   input  logic [NPATH*REG_W-1:0]        in_src_a,
   input  logic [NPATH*REG_W-1:0]        in_src_b,
   input  logic [NPATH*REG_W-1:0]        in_dst,
   output logic [NPATH-1:0]              rf_rd_en,
   output logic [NPATH*WARP_W-1:0]       rf_rd_warp,
   output logic [NPATH*REG_W-1:0]        rf_rd_reg,
   input  logic [NPATH*THREADS*DW-1:0]   rf_rd_data,
   output logic [NPATH-1:0]              wb_valid,
   output logic [NPATH*WARP_W-1:0]       wb_warp,
   output logic [NPATH*REG_W-1:0]        wb_reg,
   output logic [NPATH*THREADS*DW-1:0]   wb_data
);

   localparam int FULL = THREADS * DW;

   if (NPATH < 1) begin : g_bad_npath
      $error("opc_pair: NPATH must be at least 1");
   end

   for (genvar p = 0; p < NPATH; p++) begin : g_path
      opc_collector #(
         .DW         (DW),
         .THREADS    (THREADS),
         .LANES      (LANES),
         .WARP_W     (WARP_W),
         .REG_W      (REG_W),
         .ADDER_STYLE(ADDER_STYLE)
      ) u_coll (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_valid  (in_valid[p]),
         .in_ready  (in_ready[p]),
         .in_warp   (in_warp[p*WARP_W +: WARP_W]),
         .in_op     (in_op[p]),
         .in_src_a  (in_src_a[p*REG_W +: REG_W]),
         .in_src_b  (in_src_b[p*REG_W +: REG_W]),
         .in_dst    (in_dst[p*REG_W +: REG_W]),
         .rf_rd_en  (rf_rd_en[p]),
         .rf_rd_warp(rf_rd_warp[p*WARP_W +: WARP_W]),
         .rf_rd_reg (rf_rd_reg[p*REG_W +: REG_W]),
         .rf_rd_data(rf_rd_data[p*FULL +: FULL]),
         .wb_valid  (wb_valid[p]),
         .wb_warp   (wb_warp[p*WARP_W +: WARP_W]),
         .wb_reg    (wb_reg[p*REG_W +: REG_W]),
         .wb_data   (wb_data[p*FULL +: FULL])
      );
   end

   p_reset_idle_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (&in_ready && rf_rd_en == '0 && wb_valid == '0));

endmodule

// File: tb/opc_pair_test.sv
`timescale 1ns/1ps
module opc_pair_test;
   localparam int NP = 2;
   localparam int DW = 32;
   localparam int TH = 32;
   localparam int LN = 16;
   localparam int WW = 3;
   localparam int RW = 5;
   localparam int TD = TH * DW;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [NP-1:0]     in_valid, in_ready, in_op;
   logic [NP*WW-1:0]  in_warp;
   logic [NP*RW-1:0]  in_src_a, in_src_b, in_dst;
   logic [NP-1:0]     rf_rd_en;
   logic [NP*WW-1:0]  rf_rd_warp;
   logic [NP*RW-1:0]  rf_rd_reg;
   logic [NP*TD-1:0]  rf_rd_data;
   logic [NP-1:0]     wb_valid;
   logic [NP*WW-1:0]  wb_warp;
   logic [NP*RW-1:0]  wb_reg;
   logic [NP*TD-1:0]  wb_data;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int saw_both = 0;
   int wb_count = 0;

   bit          pend [NP];
   int          acc  [NP];
   logic [WW-1:0] pw [NP];
   logic        pop  [NP];
   logic [RW-1:0] pa [NP];
   logic [RW-1:0] pb [NP];
   logic [RW-1:0] pd [NP];

   opc_pair #(.NPATH(NP), .DW(DW), .THREADS(TH), .LANES(LN),
              .WARP_W(WW), .REG_W(RW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_warp(in_warp), .in_op(in_op), .in_src_a(in_src_a), .in_src_b(in_src_b),
      .in_dst(in_dst), .rf_rd_en(rf_rd_en), .rf_rd_warp(rf_rd_warp),
      .rf_rd_reg(rf_rd_reg), .rf_rd_data(rf_rd_data), .wb_valid(wb_valid),
      .wb_warp(wb_warp), .wb_reg(wb_reg), .wb_data(wb_data)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [DW-1:0] rf_val(int p, int w, int r, int t);
      logic [31:0] x;
      x = 32'h6A09E667 ^ (32'(w) * 32'h9E3779B9) ^ (32'(r) * 32'h85EBCA6B)
          ^ (32'(t) * 32'hC2B2AE35) ^ (32'(p) * 32'h27D4EB2F);
      x = x ^ (x >> 15);
      x = x * 32'h2C1B3C6D;
      x = x ^ (x >> 13);
      return x;
   endfunction

   function automatic logic [DW-1:0] exp_lane(int p, int w, logic op, int a, int b, int t);
      logic [DW-1:0] va, vb;
      va = rf_val(p, w, a, t);
      vb = rf_val(p, w, b, t);
      return op ? (va - vb) : (va + vb);
   endfunction

   always @(posedge clk) begin
      for (int p = 0; p < NP; p++)
         if (rf_rd_en[p])
            for (int t = 0; t < TH; t++)
               rf_rd_data[p*TD + t*DW +: DW] <=
                  rf_val(p, int'(rf_rd_warp[p*WW +: WW]), int'(rf_rd_reg[p*RW +: RW]), t);
   end

   task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic mon(int p);
      int d;
      if (pend[p]) begin
         d = cyc - acc[p];
         if (d == 0) begin
            chk(!in_ready[p], "R2", "ready low while busy", 64'(in_ready[p]), 64'd0);
            chk(rf_rd_en[p] && rf_rd_reg[p*RW +: RW] == pa[p] && rf_rd_warp[p*WW +: WW] == pw[p],
                "R3", "first read index", {rf_rd_en[p], rf_rd_warp[p*WW +: WW], rf_rd_reg[p*RW +: RW]},
                {1'b1, pw[p], pa[p]});
         end else if (d == 1) begin
            chk(rf_rd_en[p] && rf_rd_reg[p*RW +: RW] == pb[p] && rf_rd_warp[p*WW +: WW] == pw[p],
                "R3", "second read index", {rf_rd_en[p], rf_rd_warp[p*WW +: WW], rf_rd_reg[p*RW +: RW]},
                {1'b1, pw[p], pb[p]});
         end else if (d >= 2 && d <= 4) begin
            chk(!rf_rd_en[p] && !wb_valid[p] && !in_ready[p], "R9", "quiet collect/execute cycle",
                {rf_rd_en[p], wb_valid[p], in_ready[p]}, 64'd0);
         end else if (d == 5) begin
            int badlane;
            logic [DW-1:0] e, a;
            chk(wb_valid[p], "R4", "write-back strobe", 64'(wb_valid[p]), 64'd1);
            chk(wb_warp[p*WW +: WW] == pw[p] && wb_reg[p*RW +: RW] == pd[p], "R7",
                "write-back warp/reg", {wb_warp[p*WW +: WW], wb_reg[p*RW +: RW]}, {pw[p], pd[p]});
            badlane = -1;
            e = '0;
            a = '0;
            for (int t = 0; t < TH; t++) begin
               logic [DW-1:0] ee;
               ee = exp_lane(p, int'(pw[p]), pop[p], int'(pa[p]), int'(pb[p]), t);
               if (badlane < 0 && wb_data[p*TD + t*DW +: DW] !== ee) begin
                  badlane = t;
                  e = ee;
                  a = wb_data[p*TD + t*DW +: DW];
               end
            end
            chk(badlane < 0, pop[p] ? "R6" : "R5", $sformatf("lane data path %0d lane %0d", p, badlane),
                64'(a), 64'(e));
            if (pa[p] == pb[p] && pop[p]) begin
               logic zero;
               zero = (wb_data[p*TD +: TD] == '0);
               chk(zero, "R6", "same-register subtract gives zero", 64'(zero), 64'd1);
            end
            wb_count++;
            pend[p] = 1'b0;
         end
      end else begin
         chk(in_ready[p] && !rf_rd_en[p] && !wb_valid[p], "R2", "idle path state",
             {in_ready[p], rf_rd_en[p], wb_valid[p]}, 64'b100);
      end
   endtask

   task automatic drv(int p, int mode);
      logic v;
      logic [WW-1:0] w;
      logic o;
      logic [RW-1:0] a, b, dd;
      if (mode == 1) begin
         v = 1'b1; w = WW'(p + 2); o = 1'b1; a = 5'd7; b = 5'd7; dd = 5'd9;
      end else if (mode == 2) begin
         v = 1'b1; w = '1; o = 1'b0; a = '1; b = '0; dd = '1;
      end else if (mode == 3) begin
         v = 1'b0; w = '0; o = 1'b0; a = '0; b = '0; dd = '0;
      end else begin
         v = (($urandom % 10) < 7);
         w = WW'($urandom); o = 1'($urandom);
         a = RW'($urandom); b = RW'($urandom); dd = RW'($urandom);
      end
      in_valid[p]            = v;
      in_warp[p*WW +: WW]    = w;
      in_op[p]               = o;
      in_src_a[p*RW +: RW]   = a;
      in_src_b[p*RW +: RW]   = b;
      in_dst[p*RW +: RW]     = dd;
      if (v && in_ready[p]) begin
         pend[p] = 1'b1; acc[p] = cyc + 1;
         pw[p] = w; pop[p] = o; pa[p] = a; pb[p] = b; pd[p] = dd;
      end
   endtask

   initial begin
      void'($urandom(32'd4711));
      rst_n = 1'b0;
      in_valid = '0; in_warp = '0; in_op = '0;
      in_src_a = '0; in_src_b = '0; in_dst = '0;
      for (int p = 0; p < NP; p++) pend[p] = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(&in_ready && rf_rd_en == '0 && wb_valid == '0, "R1", "reset state",
          {in_ready, rf_rd_en, wb_valid}, {2'b11, 2'b00, 2'b00});
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         for (int p = 0; p < NP; p++) mon(p);
         if (wb_valid == 2'b11) saw_both++;
         for (int p = 0; p < NP; p++)
            drv(p, (i == 0) ? 1 : ((i == 10) ? 2 : 0));
      end
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         for (int p = 0; p < NP; p++) mon(p);
         if (wb_valid == 2'b11) saw_both++;
         for (int p = 0; p < NP; p++) drv(p, 3);
      end
      chk(saw_both > 0, "R8", "both paths wrote back in one cycle", 64'(saw_both), 64'd1);
      chk(!pend[0] && !pend[1], "R8", "all instructions drained", {pend[0], pend[1]}, 64'd0);
      chk(wb_count > 100, "R4", "write-back count", 64'(wb_count), 64'd101);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule